// File: doc/BRIEF.md
# Hybrid Redundancy Switch-Voter Controller

The block sits behind a bank of replicated modules, some of which vote while the rest wait as spares. Each module delivers one output word per sample. On every valid strobe the block takes a bitwise majority over the modules that are currently voting, and the registered result appears at its output. Because a single wrong module is outvoted, a fault is masked while it is being diagnosed.

Diagnosis happens in the same sample. Each voting module is compared with the majority result, and a per-module count tracks consecutive disagreeing samples. After D consecutive disagreements the module is condemned. It is then removed from the voting set, and the lowest-numbered unused spare takes its place. A removed module never votes again until reset. When no spares are left, the voting set is frozen and the block behaves as plain static majority voting. A flag reports that the spares are exhausted.

Top module: `hybrid_vote_ctrl`

## Requirements
- R1: After reset, `active_mask` has bits 0..N-1 set and the spare bits clear, `spares_left` equals S, `exhausted` is 0 (for S>0) and `voted` is 0.
- R2: `voted` is the bitwise majority, over the modules set in `active_mask`, of their words (module i occupies `mod_data[i*W +: W]`). It is registered on the clock edge that samples `valid` high, and it holds its value on cycles where `valid` is low.
- R3: The words of modules whose `active_mask` bit is clear have no effect on `voted`.
- R4: An active module is condemned when its word differs from the majority on D consecutive valid samples. A valid sample on which it agrees clears its count unless it is already condemned. Cycles with `valid` low neither advance nor clear the count.
- R5: When a module is retired, its mask bit clears and the lowest-numbered spare not yet used (spares are taken in ascending index order from N) sets, both on the same edge. `spares_left` decrements by one on that edge. When the D-th disagreement ends with the module condemned, this edge is the one that samples that disagreement.
- R6: At most one module is retired per clock edge. Among condemned modules the lowest index goes first, and a condemned module that is left over is retired on the next edge, whether or not `valid` is high.
- R7: A retired module is never made active again until reset.
- R8: `exhausted` is 1 exactly when `spares_left` is 0, and then stays 1. Once it is set, no retirement happens and `active_mask` stays fixed while voting continues.
- R9: `active_mask` always has exactly N bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | The module words are a sample to vote on |
| mod_data | input | (N+S)*W | Output words of all modules, module i at bits i*W +: W |
| voted | output | W | Registered majority word |
| active_mask | output | N+S | One bit per module, set while the module votes |
| spares_left | output | clog2(S+1) | Number of unused spares |
| exhausted | output | 1 | No spare remains |

## Verification
The bench first uses words on which all voters agree. It then uses three different words whose bitwise majority matches none of them, which separates a per-bit vote from picking any single module. Two voters each carrying a distinct single-bit error both disagree at once while the majority still masks them. This shows that retirement is ordered by index and that the leftover module goes on a strobe-free cycle. Garbage on spare and retired modules, and idle cycles between disagreements, show that only active modules vote and that strobe-free cycles leave the counts alone. The last phase makes a voter disagree again and again after exhaustion, which shows the mask is frozen while the voting still masks the fault.

// File: rtl/hybrid_vote_ctrl.sv
module hybrid_vote_ctrl #(
  parameter int W = 8,
  parameter int N = 3,
  parameter int S = 2,
  parameter int D = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid,
  input  logic [(N+S)*W-1:0]       mod_data,
  output logic [W-1:0]             voted,
  output logic [N+S-1:0]           active_mask,
  output logic [$clog2(S+1)-1:0]   spares_left,
  output logic                     exhausted
);
  localparam int M  = N + S;
  localparam int CW = $clog2(D + 1);
  localparam int SW = $clog2(S + 1);
  localparam logic [CW-1:0] DMAX = CW'(D);

  logic [M-1:0]  mask_q, mask_n, cand;
  logic [SW-1:0] spare_q;
  logic [W-1:0]  vote_q, vote_c;
  logic [CW-1:0] cnt_q [M];
  logic [CW-1:0] cnt_n [M];
  logic          sel_ok, take;
  int            sel_idx, nxt_idx;

  always_comb begin
    for (int b = 0; b < W; b++) begin
      int ones;
      ones = 0;
      for (int i = 0; i < M; i++)
        if (mask_q[i]) ones = ones + int'(mod_data[i*W+b]);
      vote_c[b] = (2 * ones > N);
    end
  end

  always_comb begin
    for (int i = 0; i < M; i++) begin
      if (!mask_q[i])
        cnt_n[i] = '0;
      else if (valid && (mod_data[i*W +: W] != vote_c))
        cnt_n[i] = (cnt_q[i] == DMAX) ? DMAX : cnt_q[i] + 1'b1;
      else if (valid && (cnt_q[i] != DMAX))
        cnt_n[i] = '0;
      else
        cnt_n[i] = cnt_q[i];
      cand[i] = mask_q[i] && (cnt_n[i] == DMAX);
    end
  end

  always_comb begin
    sel_ok  = 1'b0;
    sel_idx = 0;
    for (int i = M - 1; i >= 0; i--)
      if (cand[i]) begin
        sel_ok  = 1'b1;
        sel_idx = i;
      end
  end

  assign take    = sel_ok && (spare_q != '0);
  assign nxt_idx = N + S - int'(spare_q);

  always_comb begin
    mask_n = mask_q;
    if (take)
      for (int i = 0; i < M; i++) begin
        if (i == sel_idx) mask_n[i] = 1'b0;
        if (i == nxt_idx) mask_n[i] = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= {{S{1'b0}}, {N{1'b1}}};
      spare_q <= SW'(S);
      vote_q  <= '0;
      for (int i = 0; i < M; i++) cnt_q[i] <= '0;
    end else begin
      mask_q <= mask_n;
      if (take) spare_q <= spare_q - 1'b1;
      if (valid) vote_q <= vote_c;
      for (int i = 0; i < M; i++)
        cnt_q[i] <= (take && sel_idx == i) ? '0 : cnt_n[i];
    end
  end

  assign voted       = vote_q;
  assign active_mask = mask_q;
  assign spares_left = spare_q;
  assign exhausted   = (spare_q == '0);
endmodule

// File: rtl/hybrid_vote_ctrl_chk.sv
module hybrid_vote_ctrl_chk #(
  parameter int W = 8,
  parameter int N = 3,
  parameter int S = 2,
  parameter int D = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid,
  input logic [W-1:0]           voted,
  input logic [N+S-1:0]         active_mask,
  input logic [$clog2(S+1)-1:0] spares_left,
  input logic                   exhausted
);
  logic [N+S-1:0] prev_q, gone_q, gone_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= active_mask;
      gone_q <= '0;
    end else begin
      prev_q <= active_mask;
      gone_q <= gone_c;
    end
  end
  assign gone_c = gone_q | (prev_q & ~active_mask);

  AST_VOTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(voted)); // R2

  AST_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask & gone_c) == '0); // R7

  AST_SWAP_WITH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((spares_left != $past(spares_left)) == (active_mask != $past(active_mask)))); // R5

  AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones($past(active_mask) & ~active_mask) <= 1)); // R6

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |=> (exhausted && $stable(active_mask))); // R8

  AST_ACTIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_mask) == N); // R9
endmodule

bind hybrid_vote_ctrl hybrid_vote_ctrl_chk #(.W(W), .N(N), .S(S), .D(D)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .voted(voted),
  .active_mask(active_mask), .spares_left(spares_left), .exhausted(exhausted)
);

// File: tb/hybrid_vote_ctrl_tb.sv
`timescale 1ns/1ps
module hybrid_vote_ctrl_tb;
  localparam int W = 8, N = 3, S = 2, D = 2, M = N + S;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [M*W-1:0] mod_data = '0;
  logic [W-1:0] voted;
  logic [M-1:0] active_mask;
  logic [1:0]   spares_left;
  logic         exhausted;

  int tests = 0, fails = 0;
  logic drv_act = 1'b0, due = 1'b0;

  logic [W-1:0] qv[$];
  logic [M-1:0] qm[$];
  int           qs[$];
  string        qt[$];

  logic [M-1:0] m_mask;
  int           m_cnt [M];
  int           m_spare;
  logic [W-1:0] m_vote;

  always #2.5 clk = ~clk;

  hybrid_vote_ctrl #(.W(W), .N(N), .S(S), .D(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .mod_data(mod_data),
    .voted(voted), .active_mask(active_mask),
    .spares_left(spares_left), .exhausted(exhausted)
  );

  task automatic step(input bit v, input logic [W-1:0] a, b, c, d, e, input string tag);
    logic [W-1:0] w [M];
    logic [W-1:0] maj;
    int sel;
    @(negedge clk);
    valid    = v;
    mod_data = {e, d, c, b, a};
    drv_act  = 1'b1;
    w[0] = a; w[1] = b; w[2] = c; w[3] = d; w[4] = e;
    for (int k = 0; k < W; k++) begin
      int ones = 0;
      for (int i = 0; i < M; i++) if (m_mask[i]) ones += int'(w[i][k]);
      maj[k] = (ones * 2 > N);
    end
    sel = -1;
    for (int i = 0; i < M; i++) begin
      if (!m_mask[i]) m_cnt[i] = 0;
      else if (v && w[i] != maj) m_cnt[i] = (m_cnt[i] >= D) ? D : m_cnt[i] + 1;
      else if (v && m_cnt[i] < D) m_cnt[i] = 0;
      if (sel < 0 && m_mask[i] && m_cnt[i] == D) sel = i;
    end
    if (v) m_vote = maj;
    if (sel >= 0 && m_spare > 0) begin
      m_mask[sel] = 1'b0;
      m_mask[N + S - m_spare] = 1'b1;
      m_cnt[sel] = 0;
      m_spare--;
    end
    qv.push_back(m_vote);
    qm.push_back(m_mask);
    qs.push_back(m_spare);
    qt.push_back(tag);
  endtask

  always @(posedge clk) due <= drv_act;

  always @(negedge clk) begin
    if (due && qv.size() > 0) begin
      logic [W-1:0] ev;
      logic [M-1:0] em;
      int es;
      string t;
      ev = qv.pop_front(); em = qm.pop_front(); es = qs.pop_front(); t = qt.pop_front();
      tests++;
      if (voted !== ev || active_mask !== em || int'(spares_left) != es ||
          exhausted !== (es == 0)) begin
        fails++;
        $display("FAIL %s: voted=%h mask=%b spares=%0d exh=%b expected voted=%h mask=%b spares=%0d exh=%b",
                 t, voted, active_mask, spares_left, exhausted, ev, em, es, (es == 0));
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_mask = 5'b00111; m_spare = S; m_vote = '0;
    for (int i = 0; i < M; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (voted !== 8'h00 || active_mask !== 5'b00111 || spares_left !== 2'd2 || exhausted !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: voted=%h mask=%b spares=%0d exh=%b expected 00 00111 2 0",
               voted, active_mask, spares_left, exhausted);
    end
    step(1, 8'hA5, 8'hA5, 8'hA5, 8'h3C, 8'hC3, "R2 R3 all agree");
    step(1, 8'h66, 8'h66, 8'h66, 8'hFF, 8'h00, "R2 second agree value");
    step(1, 8'hF0, 8'hCC, 8'hAA, 8'h00, 8'h00, "R2 bitwise majority");
    step(1, 8'h5A, 8'h5A, 8'h5A, 8'h11, 8'h22, "R4 agree clears count");
    step(1, 8'h01, 8'h02, 8'h00, 8'h77, 8'h77, "R3 R4 first disagreement");
    step(0, 8'hEE, 8'hEE, 8'hEE, 8'hEE, 8'hEE, "R2 R4 idle hold");
    step(1, 8'h01, 8'h02, 8'h00, 8'h99, 8'h99, "R5 R6 lowest retired first");
    step(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R6 R8 leftover retired, exhausted");
    step(1, 8'h00, 8'h00, 8'h21, 8'h21, 8'h21, "R7 R3 retired modules ignored");
    step(1, 8'hFF, 8'hFF, 8'h3F, 8'h00, 8'h00, "R8 no retire after exhaustion");
    step(1, 8'hFF, 8'hFF, 8'h3F, 8'h00, 8'h00, "R8 condemned stays active");
    step(1, 8'hFF, 8'hFF, 8'h3F, 8'h00, 8'h00, "R8 R9 mask frozen");
    step(1, 8'h00, 8'h00, 8'h07, 8'h07, 8'h00, "R8 static masking");
    @(negedge clk);
    valid = 1'b0; drv_act = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule